// File: doc/BRIEF.md
# Alarm Indication Signal Detector

This block watches a received T1 bit stream for the all-ones alarm pattern that upstream equipment sends once it has lost its own input. It is fed one recovered bit at a time, qualified by a bit-valid strobe, together with a flag from the framer that says frame synchronization is lost. It drives one alarm status bit.

Time is cut into back-to-back observation windows of 250 microseconds. At 1.544 Mb/s that is 386 bit periods, so a window is measured by counting valid-bit strobes rather than clock cycles. Zeros are counted during each window, and the count saturates at the threshold of three. When a window closes, the alarm is set if synchronization is lost and fewer than three zeros arrived. It is cleared if three or more zeros arrived. Whenever synchronization is present the alarm is held clear, so regaining sync clears it at once.

Top module: `ais_window_detector`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the alarm, the window position and the zero count. After reset, `alarm` reads 0.
- R2: A window spans exactly `WINDOW_BITS` (default 386) strobes with `bit_valid` high. Clock cycles with `bit_valid` low do not advance the window. Windows follow one another with no gap or overlap.
- R3: When the last valid bit of a window is sampled with `sync_lost` high and the window held fewer than `ZERO_LIMIT` (default 3) zeros, `alarm` is 1 from the next cycle. The window's last bit counts toward its tally.
- R4: When the last valid bit of a window is sampled and the window held `ZERO_LIMIT` or more zeros, `alarm` is 0 from the next cycle.
- R5: In any cycle where `sync_lost` is low, `alarm` is 0 from the next cycle. No window boundary needs to occur, and the alarm can never be set while sync is present.
- R6: Zero counting saturates at `ZERO_LIMIT` and restarts at every window boundary, so zeros seen in one window have no effect on the decision for the next.
- R7: While `sync_lost` is high, `alarm` changes only in the cycle after a window's last valid bit.
- R8: A value on `bit_in` is ignored when `bit_valid` is low. A 0 there neither counts as a zero nor advances the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Strobe: `bit_in` carries a received bit this cycle |
| bit_in | input | 1 | Recovered line bit |
| sync_lost | input | 1 | High while frame synchronization is lost |
| alarm | output | 1 | Alarm indication status, 1 = all-ones alarm detected |

## Verification
The assertions check the following on every cycle:
- the window position stays in range and freezes without a strobe;
- the zero tally stays within its saturation limit, freezes without a strobe and restarts after each boundary;
- the alarm follows the set and clear decision at each boundary;
- the alarm is forced clear while sync is present;
- the alarm is held between boundaries.

Only the bench's scenarios can show the following:
- that a window really lasts 386 valid bits when strobes have gaps;
- that the 385th bit does not yet decide;
- that a heavy burst of zeros in one window leaves the next all-ones window free to raise the alarm;
- that invalid zero cycles are never counted.

// File: rtl/ais_pkg.sv
package ais_pkg;

  // Saturating add of one observed zero to a tally that stops at limit.
  function automatic int tally_next(input int cnt, input bit zero_seen, input int limit);
    int sum;
    sum = cnt + (zero_seen ? 1 : 0);
    return (sum > limit) ? limit : sum;
  endfunction

  // Window decision: alarm is raised only when sync is lost and the
  // zero tally stayed below the limit.
  function automatic bit alarm_decision(input int zeros, input int limit, input bit lost);
    return lost && (zeros < limit);
  endfunction

  // True when the given position is the final slot of a window.
  function automatic bit is_last_slot(input int pos, input int window_len);
    return pos == (window_len - 1);
  endfunction

endpackage

// File: rtl/ais_window_timer.sv
module ais_window_timer #(
  parameter int WINDOW_BITS = 386,
  localparam int WW = (WINDOW_BITS > 1) ? $clog2(WINDOW_BITS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_valid,
  output logic [WW-1:0] win_pos,
  output logic          window_end
);
  import ais_pkg::*;

  logic at_last;

  always_comb begin
    at_last    = is_last_slot(int'(win_pos), WINDOW_BITS);
    window_end = bit_valid && at_last;
  end

  always_ff @(posedge clk) begin
    if (rst)
      win_pos <= '0;
    else if (bit_valid)
      win_pos <= at_last ? '0 : win_pos + WW'(1);
  end

  // R2: position never leaves the window
  p_pos_range_r2: assert property (@(posedge clk) disable iff (rst)
    int'(win_pos) < WINDOW_BITS);

  // R2/R8: position frozen without a strobe
  p_pos_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(win_pos));

  // R2: next window starts right after a boundary
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    window_end |=> win_pos == '0);

  // R1
  p_reset_pos_r1: assert property (@(posedge clk)
    rst |=> win_pos == '0);

endmodule

// File: rtl/ais_zero_tally.sv
module ais_zero_tally #(
  parameter int ZERO_LIMIT = 3,
  localparam int CW = $clog2(ZERO_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bit_valid,
  input  logic          bit_in,
  input  logic          window_end,
  output logic [CW-1:0] tally,
  output logic [CW-1:0] zeros_seen
);
  import ais_pkg::*;

  logic zero_hit;

  always_comb begin
    zero_hit   = bit_valid && !bit_in;
    zeros_seen = CW'(tally_next(int'(tally), zero_hit, ZERO_LIMIT));
  end

  always_ff @(posedge clk) begin
    if (rst || window_end)
      tally <= '0;
    else
      tally <= zeros_seen;
  end

  // R6: saturation bound
  p_tally_sat_r6: assert property (@(posedge clk) disable iff (rst)
    int'(tally) <= ZERO_LIMIT);

  // R6: restart at boundary
  p_tally_restart_r6: assert property (@(posedge clk) disable iff (rst)
    window_end |=> tally == '0);

  // R8: invalid cycles do not count
  p_tally_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> $stable(tally));

  // R1
  p_reset_tally_r1: assert property (@(posedge clk)
    rst |=> tally == '0);

endmodule

// File: rtl/ais_alarm_ctrl.sv
module ais_alarm_ctrl #(
  parameter int ZERO_LIMIT = 3,
  localparam int CW = $clog2(ZERO_LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sync_lost,
  input  logic          window_end,
  input  logic [CW-1:0] zeros_seen,
  output logic          alarm
);
  import ais_pkg::*;

  logic decide_set;
  logic sync_ok;

  always_comb begin
    sync_ok    = !sync_lost;
    decide_set = alarm_decision(int'(zeros_seen), ZERO_LIMIT, sync_lost);
  end

  always_ff @(posedge clk) begin
    if (rst || sync_ok)
      alarm <= 1'b0;
    else if (window_end)
      alarm <= decide_set;
  end

  // R3
  p_set_r3: assert property (@(posedge clk) disable iff (rst)
    (window_end && sync_lost && int'(zeros_seen) < ZERO_LIMIT) |=> alarm);

  // R4
  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (window_end && int'(zeros_seen) >= ZERO_LIMIT) |=> !alarm);

  // R5
  p_sync_clear_r5: assert property (@(posedge clk) disable iff (rst)
    !sync_lost |=> !alarm);

  // R7
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (sync_lost && !window_end) |=> alarm == $past(alarm));

  // R1
  p_reset_alarm_r1: assert property (@(posedge clk)
    rst |=> !alarm);

endmodule

// File: rtl/ais_window_detector.sv
module ais_window_detector #(
  parameter int WINDOW_BITS = 386,
  parameter int ZERO_LIMIT  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic bit_in,
  input  logic sync_lost,
  output logic alarm
);
  localparam int WW = (WINDOW_BITS > 1) ? $clog2(WINDOW_BITS) : 1;
  localparam int CW = $clog2(ZERO_LIMIT + 1);

  logic [WW-1:0] win_pos;
  logic          window_end;
  logic [CW-1:0] tally;
  logic [CW-1:0] zeros_seen;

  ais_window_timer #(.WINDOW_BITS(WINDOW_BITS)) u_timer (
    .clk(clk), .rst(rst), .bit_valid(bit_valid),
    .win_pos(win_pos), .window_end(window_end)
  );

  ais_zero_tally #(.ZERO_LIMIT(ZERO_LIMIT)) u_tally (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .window_end(window_end), .tally(tally), .zeros_seen(zeros_seen)
  );

  ais_alarm_ctrl #(.ZERO_LIMIT(ZERO_LIMIT)) u_ctrl (
    .clk(clk), .rst(rst), .sync_lost(sync_lost),
    .window_end(window_end), .zeros_seen(zeros_seen), .alarm(alarm)
  );

endmodule

// File: tb/sim_ais_window_detector.sv
module sim_ais_window_detector;
  localparam int WIN   = 386;
  localparam int LIMIT = 3;

  logic clk = 1'b0;
  logic rst, bit_valid, bit_in, sync_lost;
  logic alarm;

  int n_checks = 0;
  int n_fail   = 0;
  string tag = "R1";

  // reference model state
  int  m_pos   = 0;
  int  m_zeros = 0;
  bit  m_alarm = 0;

  always #2.5 clk = ~clk;

  ais_window_detector #(.WINDOW_BITS(WIN), .ZERO_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .sync_lost(sync_lost), .alarm(alarm)
  );

  task automatic check(input string req, input logic act, input bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: alarm=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(input bit r, input bit v, input bit b, input bit s);
    rst = r; bit_valid = v; bit_in = b; sync_lost = s;
    @(posedge clk);
    if (r) begin
      m_pos = 0; m_zeros = 0; m_alarm = 0;
    end else begin
      bit closing;
      closing = 0;
      if (v) begin
        if (!b) m_zeros++;
        m_pos++;
        if (m_pos == WIN) closing = 1;
      end
      if (!s) m_alarm = 0;
      else if (closing) m_alarm = (m_zeros < LIMIT);
      if (closing) begin m_pos = 0; m_zeros = 0; end
    end
    @(negedge clk);
    check(tag, alarm, m_alarm);
  endtask

  // full window of valid bits, first nz are zeros, optional invalid zero gaps
  task automatic run_window(input int nz, input bit s, input bit gaps);
    for (int i = 0; i < WIN; i++) begin
      step(0, 1, (i < nz) ? 1'b0 : 1'b1, s);
      if (gaps) step(0, 0, 0, s);
    end
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst = 1; bit_valid = 0; bit_in = 1; sync_lost = 0;
    @(negedge clk);
    tag = "R1"; step(1, 0, 1, 1); step(1, 0, 1, 1);
    check("R1 reset", alarm, 0);

    tag = "R3"; run_window(0, 1, 0);
    check("R3 all-ones window sets alarm", alarm, 1);
    run_window(2, 1, 0);
    check("R3 two zeros keeps alarm", alarm, 1);

    tag = "R4"; run_window(3, 1, 0);
    check("R4 three zeros clears alarm", alarm, 0);

    tag = "R6"; run_window(150, 1, 0);
    check("R6 heavy zeros keeps clear", alarm, 0);
    run_window(0, 1, 0);
    check("R6 tally restarted, alarm set", alarm, 1);

    tag = "R7"; for (int i = 0; i < 100; i++) step(0, 1, 0, 1);
    check("R7 alarm held mid-window", alarm, 1);
    for (int i = 100; i < WIN; i++) step(0, 1, 1, 1);
    check("R4 closing window with zeros clears", alarm, 0);

    tag = "R2"; for (int i = 0; i < WIN - 1; i++) begin step(0, 1, 1, 1); step(0, 0, 1, 1); end
    check("R2 not decided after 385 bits", alarm, 0);
    step(0, 1, 1, 1);
    check("R2 decided on 386th bit", alarm, 1);

    tag = "R5"; for (int i = 0; i < 50; i++) step(0, 1, 1, 1);
    step(0, 1, 1, 0);
    check("R5 sync regained clears at once", alarm, 0);
    for (int i = 51; i < WIN; i++) step(0, 1, 1, 0);
    run_window(0, 0, 0);
    check("R5 no alarm while in sync", alarm, 0);

    tag = "R8"; run_window(0, 1, 1);
    check("R8 invalid zeros ignored", alarm, 1);

    tag = "R1"; step(1, 1, 1, 1);
    check("R1 reset mid-run", alarm, 0);
    tag = "R3"; run_window(LIMIT - 1, 1, 0);
    check("R3 below limit after reset", alarm, 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule